// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block is the hazard controller for a five-stage in-order pipeline. It sits beside the decode and execute stages and watches two instructions. One is the instruction in decode, seen through its two source register fields. The other is the instruction in execute, seen through its destination field, its memory-read flag and the branch outcome resolved there. From these it drives the enables and squash controls of the front of the pipeline.

A load in execute is followed directly by an instruction in decode that reads the loaded register. The loaded value only exists after the memory stage, so bypassing cannot help. The controller freezes the program counter and the fetch/decode register for one cycle and sends an empty slot into execute. Branches are assumed not taken. When execute resolves a branch as taken, the two younger instructions already fetched are squashed. The word about to enter the fetch/decode register is replaced by the all-zero no-op, and the instruction leaving decode becomes a bubble in execute. The branch redirect takes precedence over any load-use stall in the same cycle.

All outputs are combinational in the current inputs. A single state bit records that the previous cycle was a stall cycle, so that a stall never lasts longer than one cycle.

Top module: `hazard_ctl`

## Requirements
- R1: With `ex_mem_read`=1, `ex_branch_taken`=0, a nonzero `ex_rt` equal to `id_rs`, and no stall in the previous cycle, the controller drives `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1 in that same cycle.
- R2: The same stall as in R1 occurs when the nonzero `ex_rt` equals `id_rt` instead of `id_rs`.
- R3: With `ex_mem_read`=0, or with `ex_rt` matching neither source field, and no taken branch, the outputs are `pc_we`=1, `ifid_we`=1, `idex_bubble`=0 and `ifid_flush`=0.
- R4: A load whose destination is register 0 never causes a stall, even when both source fields are also 0.
- R5: A stall lasts exactly one cycle. In the cycle after a stall cycle, `pc_we` and `ifid_we` are 1 even if the load-use condition is still presented. If the condition is still present in the cycle after that, the controller stalls again.
- R6: With `ex_branch_taken`=1, the outputs are `ifid_flush`=1, `idex_bubble`=1, `pc_we`=1 and `ifid_we`=1.
- R7: During a flush, `ifid_insn_d` is the all-zero word. In every other cycle it equals `if_insn`.
- R8: A taken branch overrides a load-use condition in the same cycle, giving the R6 outputs with no stall. The overridden condition does not count as a stall, so a load-use condition in the next cycle stalls.
- R9: While `rst_n`=0 the stall history is cleared. In the first cycle after reset release, a load-use condition stalls immediately, and idle inputs give the R3 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| ex_rt | input | REG_W | Load destination register of the execute instruction |
| ex_mem_read | input | 1 | Execute instruction reads data memory |
| ex_branch_taken | input | 1 | Branch in execute resolved taken |
| if_insn | input | INSN_W | Word fetched this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields entering execute |
| ifid_flush | output | 1 | Fetch/decode register loads a no-op |
| ifid_insn_d | output | INSN_W | Word to load into the fetch/decode register |

## Verification
Every output responds in the same cycle as the inputs that cause it. The bench therefore drives each stimulus shortly after a rising edge and samples the outputs before the next one. The single history bit changes what the controller does only one edge later. The one-cycle stall limit and the branch-over-stall history are therefore checked over runs of consecutive cycles. The load-use pattern is held across three edges and the outputs are compared in each cycle: stall, release, then stall again. In the table walk, an idle cycle follows every vector, so the history bit is clear before the next entry.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_W  = 5,
  parameter int INSN_W = 32,
  parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic              ex_mem_read,
  input  logic              ex_branch_taken,
  input  logic [INSN_W-1:0] if_insn,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic [INSN_W-1:0] ifid_insn_d
);

  logic stall_q;
  logic src_hit;
  logic load_use;
  logic stall;

  assign src_hit  = (ex_rt == id_rs) || (ex_rt == id_rt);
  assign load_use = ex_mem_read && (ex_rt != '0) && src_hit;
  assign stall    = load_use && !stall_q && !ex_branch_taken;

  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall || ex_branch_taken;
  assign ifid_flush  = ex_branch_taken;
  assign ifid_insn_d = ex_branch_taken ? NOP_WORD : if_insn;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  assert_load_use_rs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && !ex_branch_taken && ex_rt != '0 && ex_rt == id_rs && !stall_q)
      |-> (!pc_we && !ifid_we && idex_bubble));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_mem_read && !ex_branch_taken) |-> (pc_we && ifid_we && !idex_bubble && !ifid_flush));

  assert_zero_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt == '0) |-> pc_we);

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> pc_we);

  assert_flush_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (idex_bubble && pc_we && ifid_we));

  assert_flush_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (ifid_insn_d == NOP_WORD));

  assert_branch_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_branch_taken |=> !stall_q);

endmodule

// File: tb/hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module hazard_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  id_rs = '0, id_rt = '0, ex_rt = '0;
  logic        ex_mem_read = 1'b0, ex_branch_taken = 1'b0;
  logic [31:0] if_insn = '0;
  logic        pc_we, ifid_we, idex_bubble, ifid_flush;
  logic [31:0] ifid_insn_d;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hazard_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt), .ex_rt(ex_rt),
    .ex_mem_read(ex_mem_read), .ex_branch_taken(ex_branch_taken), .if_insn(if_insn),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .ifid_insn_d(ifid_insn_d)
  );

  // {mem_read, taken, ex_rt, id_rs, id_rt, exp_pc_we, exp_bubble, exp_flush}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd5,  5'd5,  5'd5,  1'b1, 1'b0, 1'b0},  // R3
    {1'b1, 1'b0, 5'd5,  5'd5,  5'd7,  1'b0, 1'b1, 1'b0},  // R1
    {1'b1, 1'b0, 5'd9,  5'd3,  5'd9,  1'b0, 1'b1, 1'b0},  // R2
    {1'b1, 1'b0, 5'd4,  5'd3,  5'd6,  1'b1, 1'b0, 1'b0},  // R3
    {1'b1, 1'b0, 5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0},  // R4
    {1'b0, 1'b1, 5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 1'b1},  // R6
    {1'b1, 1'b1, 5'd8,  5'd8,  5'd2,  1'b1, 1'b1, 1'b1},  // R8
    {1'b0, 1'b0, 5'd31, 5'd31, 5'd31, 1'b1, 1'b0, 1'b0},  // R3
    {1'b1, 1'b0, 5'd31, 5'd1,  5'd31, 0'b0 == 0 ? 1'b0 : 1'b0, 1'b1, 1'b0},  // R2
    {1'b0, 1'b1, 5'd12, 5'd12, 5'd12, 1'b1, 1'b1, 1'b1}   // R6
  };

  task automatic drive(input logic mr, input logic br, input logic [4:0] er,
                       input logic [4:0] rs, input logic [4:0] rt, input logic [31:0] ins);
    ex_mem_read = mr; ex_branch_taken = br; ex_rt = er; id_rs = rs; id_rt = rt; if_insn = ins;
  endtask

  task automatic expect_out(input string tag, input logic pw, input logic bub, input logic fl,
                            input logic [31:0] word);
    checks++;
    if (pc_we !== pw || ifid_we !== pw || idex_bubble !== bub || ifid_flush !== fl ||
        ifid_insn_d !== word) begin
      errors++;
      $display("FAIL %s: got pc_we=%b ifid_we=%b bubble=%b flush=%b word=%h, expected pc_we=%b ifid_we=%b bubble=%b flush=%b word=%h",
               tag, pc_we, ifid_we, idex_bubble, ifid_flush, ifid_insn_d, pw, pw, bub, fl, word);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state with idle inputs
    repeat (3) @(posedge clk);
    #1;
    expect_out("R9 in reset", 1'b1, 1'b0, 1'b0, 32'h0);
    drive(1'b1, 1'b0, 5'd6, 5'd6, 5'd0, 32'h1111_2222);
    @(posedge clk); #1;
    rst_n = 1'b1;
    #1;
    // R9: first cycle after release, history clear, stall at once
    expect_out("R9 first stall", 1'b0, 1'b1, 1'b0, 32'h1111_2222);
    drive(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 32'h0);
    next_cycle();

    // table walk, idle cycle between entries clears history
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      logic [31:0] ins;
      v = VEC[i];
      ins = 32'hA500_0000 + 32'(i) + 32'h1;
      drive(v[19], v[18], v[17:13], v[12:8], v[7:3], ins);
      #1;
      expect_out($sformatf("R1/R2/R3/R4/R6/R7/R8 vector %0d", i), v[2], v[1], v[0],
                 v[0] ? 32'h0 : ins);
      next_cycle();
      drive(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 32'h0);
      next_cycle();
    end

    // R5: hazard held for three cycles -> stall, release, stall
    drive(1'b1, 1'b0, 5'd10, 5'd10, 5'd10, 32'hCAFE_0001);
    #1;
    expect_out("R5 cycle 1 stall", 1'b0, 1'b1, 1'b0, 32'hCAFE_0001);
    next_cycle();
    expect_out("R5 cycle 2 release", 1'b1, 1'b0, 1'b0, 32'hCAFE_0001);
    next_cycle();
    expect_out("R5 cycle 3 stall again", 1'b0, 1'b1, 1'b0, 32'hCAFE_0001);
    next_cycle();
    drive(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 32'h0);
    next_cycle();

    // R8: branch over hazard, then hazard next cycle stalls
    drive(1'b1, 1'b1, 5'd3, 5'd3, 5'd3, 32'hDEAD_BEEF);
    #1;
    expect_out("R8 branch wins", 1'b1, 1'b1, 1'b1, 32'h0);
    next_cycle();
    ex_branch_taken = 1'b0;
    #1;
    expect_out("R8 stall after override", 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF);
    next_cycle();
    drive(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 32'h0);
    next_cycle();

    // R7: pass-through and zero word on flush
    drive(1'b0, 1'b0, 5'd1, 5'd2, 5'd3, 32'hFFFF_FFFF);
    #1;
    expect_out("R7 pass-through", 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
    ex_branch_taken = 1'b1;
    #1;
    expect_out("R7 zero on flush", 1'b1, 1'b1, 1'b1, 32'h0);
    next_cycle();

    // R4: reg 0 held as load target over several cycles never stalls
    drive(1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 32'h0000_0042);
    for (int k = 0; k < 3; k++) begin
      #1;
      expect_out("R4 zero dest held", 1'b1, 1'b0, 1'b0, 32'h0000_0042);
      next_cycle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule